// File: doc/BRIEF.md
# Sprite Table DMA Engine

This block fills a 160-entry sprite attribute table in a fixed window of the address map by copying bytes from memory, one byte for each active machine cycle. Software starts a copy with a single register write. The value written becomes the high byte (the page) of the source address. The low byte of the source address starts at zero and counts upward.

Every byte is fetched one step before it is stored. The engine therefore makes 161 steps. The first step only fetches, the middle steps each store the byte held from the previous step and fetch the next one, and the last step only stores. A busy flag tells the memory arbiter when the engine is storing into the table. Whenever the processor is halted the engine stops in place, and it carries on from the same point once the halt is released.

Top module: `spr_dma`

## Requirements
- R1: After reset the busy flag, the read strobe and the write strobe are all low, and the register read port returns 0.
- R2: A write on the register port stores the written byte as the source page, and from then on the register read port returns the last byte written.
- R3: After a register write in cycle C0, the engine makes no memory access in C1. In C2 it asserts the read strobe with the read address equal to page*256, while busy stays low. In C3 it performs its first table write and busy goes high. Here C1, C2 and C3 are the next active cycles after C0.
- R4: For every index i from 0 to 159, the engine writes the byte it read from page*256+i to address 0xFE00+i. The writes go in ascending order, one per active cycle.
- R5: Busy is high for exactly 160 active cycles per completed copy. It is low during the fetch-only step and low after the last write.
- R6: While the halt input is high, the engine issues no read and no write strobe, and the transfer counter, the data buffer and a pending start are all held. The copy resumes at the same index once the halt input goes low.
- R7: A register write during a running copy restarts the copy from index 0 using the new page, after the same start latency as R3. When that restarted copy finishes, the table holds the new page's bytes.
- R8: The read strobe is high on 160 steps per copy: the fetch-only step and each write step except the last. The step that writes index 159 makes no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe; starts a copy |
| reg_wdata | input | 8 | Source page written by software |
| reg_rdata | output | 8 | Last source page written |
| cpu_halt | input | 1 | High while the processor is halted; freezes the engine |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data for mem_raddr, returned in the same cycle |
| mem_we | output | 1 | Table write strobe |
| mem_waddr | output | 16 | Table write address |
| mem_wdata | output | 8 | Table write data |
| busy | output | 1 | High while the engine is storing into the table |

## Verification
A counter that is off by one shows up at the ports within a cycle. Busy would rise together with the first read instead of one cycle later, or the first write would land at 0xFE01 instead of 0xFE00. A data buffer that captures on the wrong step puts every table entry one index away from its source, which a full comparison of the table exposes after 161 cycles. If the logic that freezes the engine is broken, a strobe appears during the halt window or the busy cycle count no longer equals 160. If the restart logic is broken, the table ends up holding bytes from the old page.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  // Width of a down-counter that must hold len+1 (the fetch-only step).
  function automatic int unsigned step_cnt_width(input int unsigned len);
    return $clog2(len + 2);
  endfunction
endpackage

// File: rtl/spr_dma_regs.sv
module spr_dma_regs #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              reg_we,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] src_page,
  output logic              load
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_page <= '0;
      armed    <= 1'b0;
    end else begin
      if (reg_we) src_page <= reg_wdata;
      if (reg_we)      armed <= 1'b1;
      else if (active) armed <= 1'b0;
    end
  end

  // The pending start fires on the first active cycle after the write.
  assign load = armed && active;

  // R2
  page_store_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> src_page == $past(reg_wdata));

  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !active && !reg_we) |=> armed);
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int unsigned LEN = 160,
  localparam int unsigned CNT_W = step_cnt_width(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             load,
  output logic [CNT_W-1:0] cnt,
  output logic             rd_step,
  output logic             wr_step,
  output logic             busy
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN);

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (load)                    cnt <= FULL;
    else if (active && cnt != '0)     cnt <= cnt - 1'b1;
  end

  // Step k (counter value k) stores index LEN-k and fetches index LEN+1-k.
  assign wr_step = (cnt != '0) && (cnt <= LAST);
  assign rd_step = (cnt > CNT_W'(1));
  assign busy    = (cnt != '0) && (cnt != FULL);

  // R6
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(cnt));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == FULL);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/spr_dma_buf.sv
module spr_dma_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  // R6
  buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q));
endmodule

// File: rtl/spr_dma.sv
module spr_dma
  import spr_dma_pkg::*;
#(
  parameter int unsigned LEN       = 160,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEST_BASE = 'hFE00,
  localparam int unsigned ADDR_W   = PAGE_W + OFS_W,
  localparam int unsigned CNT_W    = step_cnt_width(LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  input  logic              cpu_halt,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DEST_BASE);

  logic              active;
  logic              load;
  logic [PAGE_W-1:0] src_page;
  logic [CNT_W-1:0]  cnt;
  logic              rd_step;
  logic              wr_step;
  logic [CNT_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  wr_idx;

  assign active = !cpu_halt;

  spr_dma_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst), .active(active),
    .reg_we(reg_we), .reg_wdata(reg_wdata),
    .src_page(src_page), .load(load)
  );

  spr_dma_seq #(.LEN(LEN)) u_seq (
    .clk(clk), .rst(rst), .active(active), .load(load),
    .cnt(cnt), .rd_step(rd_step), .wr_step(wr_step), .busy(busy)
  );

  spr_dma_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .cap(mem_re), .d(mem_rdata), .q(mem_wdata)
  );

  assign rd_idx    = CNT_W'(LEN + 1) - cnt;
  assign wr_idx    = CNT_W'(LEN) - cnt;
  assign mem_re    = active && rd_step;
  assign mem_we    = active && wr_step;
  assign mem_raddr = {src_page, {OFS_W{1'b0}}} + ADDR_W'(rd_idx);
  assign mem_waddr = BASE + ADDR_W'(wr_idx);
  assign reg_rdata = src_page;

  // R5
  busy_store_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cpu_halt) |-> mem_we);

  // R4
  window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr - BASE) < ADDR_W'(LEN));

  // R8
  last_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_waddr == BASE + ADDR_W'(LEN - 1)) |-> !mem_re);

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> (!mem_re && !mem_we));
endmodule

// File: tb/spr_dma_test.sv
module spr_dma_test;
  localparam int CLK_P = 10;
  localparam int LEN   = 160;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_halt = 1'b0;
  logic        mem_re;
  logic [15:0] mem_raddr;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic [15:0] mem_waddr;
  logic [7:0]  mem_wdata;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;
  int wr_cnt, rd_cnt, busy_cyc, oob_cnt;
  logic [7:0] table_q [LEN];

  always #(CLK_P/2) clk = ~clk;

  spr_dma uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_halt(cpu_halt), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .busy(busy)
  );

  function automatic logic [7:0] src_byte(input logic [7:0] page, input int idx);
    return (8'(idx) ^ 8'hA5) + page;
  endfunction

  assign mem_rdata = src_byte(mem_raddr[15:8], int'(mem_raddr[7:0]));

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        wr_cnt = wr_cnt + 1;
        if (mem_waddr >= 16'hFE00 && mem_waddr < 16'hFE00 + LEN)
          table_q[int'(mem_waddr - 16'hFE00)] = mem_wdata;
        else
          oob_cnt = oob_cnt + 1;
      end
      if (mem_re) rd_cnt = rd_cnt + 1;
      if (busy && !cpu_halt) busy_cyc = busy_cyc + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    wr_cnt = 0; rd_cnt = 0; busy_cyc = 0; oob_cnt = 0;
    for (int i = 0; i < LEN; i++) table_q[i] = 8'h00;
  endtask

  task automatic reg_write(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic chk_table(input string req, input logic [7:0] page);
    int bad = 0;
    for (int i = 0; i < LEN; i++)
      if (table_q[i] != src_byte(page, i)) bad++;
    chk(req, "table mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "reg_rdata", int'(reg_rdata), 0);
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "mem_re", int'(mem_re), 0);
  endtask

  task automatic t_full_copy();
    clear_stats();
    reg_write(8'h12);
    chk("R3", "C1 busy", int'(busy), 0);
    chk("R3", "C1 mem_re", int'(mem_re), 0);
    @(negedge clk);
    chk("R3", "C2 mem_re", int'(mem_re), 1);
    chk("R3", "C2 raddr", int'(mem_raddr), 'h1200);
    chk("R3", "C2 busy", int'(busy), 0);
    chk("R3", "C2 mem_we", int'(mem_we), 0);
    @(negedge clk);
    chk("R3", "C3 busy", int'(busy), 1);
    chk("R4", "C3 waddr", int'(mem_waddr), 'hFE00);
    chk("R4", "C3 wdata", int'(mem_wdata), int'(src_byte(8'h12, 0)));
    chk("R8", "C3 raddr", int'(mem_raddr), 'h1201);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R4", "write count", wr_cnt, LEN);
    chk("R4", "out of window writes", oob_cnt, 0);
    chk_table("R4", 8'h12);
    chk("R5", "busy cycles", busy_cyc, LEN);
    chk("R5", "busy after", int'(busy), 0);
    chk("R8", "read count", rd_cnt, LEN);
    chk("R2", "reg_rdata", int'(reg_rdata), 'h12);
  endtask

  task automatic t_halt_mid();
    logic [15:0] held;
    int strobes = 0, not_busy = 0, moved = 0;
    clear_stats();
    reg_write(8'h40);
    repeat (30) @(negedge clk);
    cpu_halt = 1'b1;
    held = mem_waddr;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (mem_we || mem_re) strobes++;
      if (!busy) not_busy++;
      if (mem_waddr != held) moved++;
    end
    chk("R6", "strobes in halt", strobes, 0);
    chk("R6", "busy dropped in halt", not_busy, 0);
    chk("R6", "index moved in halt", moved, 0);
    cpu_halt = 1'b0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R6", "write count", wr_cnt, LEN);
    chk("R6", "active busy cycles", busy_cyc, LEN);
    chk_table("R6", 8'h40);
  endtask

  task automatic t_halt_pending();
    int act = 0;
    clear_stats();
    cpu_halt = 1'b1;
    reg_write(8'h77);
    for (int k = 0; k < 10; k++) begin
      if (busy || mem_re || mem_we) act++;
      @(negedge clk);
    end
    chk("R6", "activity with start pending", act, 0);
    cpu_halt = 1'b0;
    @(negedge clk);
    chk("R6", "fetch after release", int'(mem_re), 1);
    chk("R6", "fetch addr after release", int'(mem_raddr), 'h7700);
    chk("R6", "busy on fetch step", int'(busy), 0);
    @(negedge clk);
    chk("R6", "busy after release", int'(busy), 1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk_table("R6", 8'h77);
  endtask

  task automatic t_restart();
    clear_stats();
    reg_write(8'h21);
    repeat (50) @(negedge clk);
    reg_write(8'h33);
    @(negedge clk);
    chk("R7", "busy on restart fetch", int'(busy), 0);
    chk("R7", "restart fetch addr", int'(mem_raddr), 'h3300);
    @(negedge clk);
    chk("R7", "restart first waddr", int'(mem_waddr), 'hFE00);
    chk("R7", "restart first wdata", int'(mem_wdata), int'(src_byte(8'h33, 0)));
    wait_idle();
    repeat (2) @(negedge clk);
    chk_table("R7", 8'h33);
    chk("R2", "reg_rdata after rewrite", int'(reg_rdata), 'h33);
  endtask

  task automatic t_idle();
    int act = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy || mem_we || mem_re) act++;
    end
    chk("R5", "idle activity", act, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_copy();
    t_halt_mid();
    t_halt_pending();
    t_restart();
    t_idle();
    finish_run();
  end
endmodule